// File: doc/BRIEF.md
# Sized Address Window Decoder

This block decides whether a bus access lands inside one programmable memory window. The window begins at a base address. Its length is a power of two chosen by a 5-bit exponent N, so it spans 2^N bytes, from 1 byte up to 2 GB. The top byte of the window address is fixed at 1Fh. Only the low 24 base bits are programmable. The base is aligned down to the window length without any notice: base bits below N take no part in the decode.

On each access strobe, the block reports one of two results one clock later. It either raises a hit, or, if the address lies in the region's decode area (top address byte equal to 1Fh) but outside the window, it raises a one-cycle address-error pulse. That pulse is meant as the exception request. An error also sets a sticky flag, which software clears by writing 1 to its bit. A small register write port loads the base register and the control register. Both registers are always visible on read-back outputs.

Top module: `win_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, win_hit and addr_err are 0, base_rdata reads 1F000000h and ctrl_rdata reads 0.
- R2: A write with reg_sel=0 stores reg_wdata[23:0] as the base, visible on base_rdata after the write edge. base_rdata[31:24] always reads 1Fh, whatever was written.
- R3: A write with reg_sel=1 stores reg_wdata[20:16] as the size exponent N, read back at ctrl_rdata[20:16]. Every ctrl_rdata bit other than 20:16 and 28 reads 0, including bits 23:21.
- R4: An access with acc_valid=1 gives win_hit=1 in the next cycle exactly when acc_addr[31:N] equals the effective base {1Fh, base}[31:N]. Base bits below N are ignored. Register values from before a same-cycle write apply to that access.
- R5: When N is 24 or more, only address bits N..31 are compared. With N=31, any address whose bit 31 is 0 hits.
- R6: An access whose acc_addr[31:24] is 1Fh but which misses the window gives addr_err=1 for exactly the next cycle. Consecutive such accesses give consecutive pulses.
- R7: With acc_valid=0, or with an address outside the decode area that misses the window, neither win_hit nor addr_err is raised. The two are never 1 together.
- R8: An address error sets a sticky flag at ctrl_rdata[28] at the same edge that raises addr_err. The flag then stays set.
- R9: A control write with reg_wdata[28]=1 clears the flag. A control write with bit 28 at 0 leaves it unchanged. A clear and a new error at the same edge leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Access byte address |
| reg_wr | input | 1 | Register write enable |
| reg_sel | input | 1 | 0 selects the base register, 1 selects the control register |
| reg_wdata | input | 32 | Register write data |
| win_hit | output | 1 | Registered: the last access fell inside the window |
| addr_err | output | 1 | Registered one-cycle address-error pulse |
| base_rdata | output | 32 | Base register read-back, top byte fixed at 1Fh |
| ctrl_rdata | output | 32 | Control read-back: exponent in 20:16, error flag in 28 |

## Verification
The bound checker tests these rules on every cycle: hit and error never occur together, either result needs a strobe in the previous cycle, and an error needs that address to be in the decode area. It also checks that the flag is set along with every error pulse, that the flag stays set unless a clear write came first, that a clear write without a concurrent error leaves it clear, and that the fixed and zero read-back bits never change. Only the bench's scenarios can show that the window bounds are correct: the exact edges of aligned windows of different sizes, the ignored low base bits, the wide exponents that reach past the decode area, and the use of old register values on an access that meets a write.

// File: rtl/win_pkg.sv
package win_pkg;
  // Control register field positions decoded by software
  localparam int CTRL_SIZE_LSB = 16;
  localparam int CTRL_FLAG_BIT = 28;

  typedef enum logic {
    SEL_BASE = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/win_regs.sv
module win_regs #(
  parameter int BASE_W = 24,
  parameter int SIZE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_base,
  input  logic              wr_ctrl,
  input  logic [BASE_W-1:0] base_wd,
  input  logic [SIZE_W-1:0] size_wd,
  input  logic              clr_wd,
  input  logic              err_set,
  output logic [BASE_W-1:0] base_q,
  output logic [SIZE_W-1:0] size_q,
  output logic              flag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      size_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_base) base_q <= base_wd;
      if (wr_ctrl) size_q <= size_wd;
      // A new error wins over a same-edge clear
      if (err_set)                flag_q <= 1'b1;
      else if (wr_ctrl && clr_wd) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/win_match.sv
module win_match #(
  parameter int ADDR_W = 32,
  parameter int BASE_W = 24,
  parameter int SIZE_W = 5,
  parameter logic [ADDR_W-BASE_W-1:0] TOP_VAL = 'h1F
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base,
  input  logic [SIZE_W-1:0] size,
  output logic              in_win,
  output logic              in_area
);
  logic [ADDR_W-1:0] eff_base;
  logic [ADDR_W-1:0] care;

  assign eff_base = {TOP_VAL, base};

  // Bit i takes part in the compare only at or above the exponent
  for (genvar i = 0; i < ADDR_W; i++) begin : g_care
    assign care[i] = (32'(i) >= 32'(size));
  end

  assign in_win  = ~|((addr ^ eff_base) & care);
  assign in_area = (addr[ADDR_W-1:BASE_W] == TOP_VAL);
endmodule

// File: rtl/win_decoder.sv
module win_decoder #(
  parameter int ADDR_W = 32,
  parameter int BASE_W = 24,
  parameter int SIZE_W = 5,
  parameter logic [ADDR_W-BASE_W-1:0] TOP_VAL = 'h1F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic              win_hit,
  output logic              addr_err,
  output logic [ADDR_W-1:0] base_rdata,
  output logic [ADDR_W-1:0] ctrl_rdata
);
  import win_pkg::*;

  logic [BASE_W-1:0] base_q;
  logic [SIZE_W-1:0] size_q;
  logic              flag_q;
  logic              in_win, in_area;
  logic              err_now;
  logic              wr_base, wr_ctrl;
  logic              unused_wdata;

  assign wr_base      = reg_wr && (reg_sel_e'(reg_sel) == SEL_BASE);
  assign wr_ctrl      = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTRL);
  assign unused_wdata = ^reg_wdata;

  win_match #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .SIZE_W(SIZE_W), .TOP_VAL(TOP_VAL)
  ) u_match (
    .addr(acc_addr), .base(base_q), .size(size_q),
    .in_win(in_win), .in_area(in_area)
  );

  assign err_now = acc_valid && in_area && !in_win;

  win_regs #(.BASE_W(BASE_W), .SIZE_W(SIZE_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_base(wr_base), .wr_ctrl(wr_ctrl),
    .base_wd(reg_wdata[BASE_W-1:0]),
    .size_wd(reg_wdata[CTRL_SIZE_LSB +: SIZE_W]),
    .clr_wd(reg_wdata[CTRL_FLAG_BIT]),
    .err_set(err_now),
    .base_q(base_q), .size_q(size_q), .flag_q(flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      win_hit  <= 1'b0;
      addr_err <= 1'b0;
    end else begin
      win_hit  <= acc_valid && in_win;
      addr_err <= err_now;
    end
  end

  assign base_rdata = {TOP_VAL, base_q};

  always_comb begin
    ctrl_rdata = '0;
    ctrl_rdata[CTRL_SIZE_LSB +: SIZE_W] = size_q;
    ctrl_rdata[CTRL_FLAG_BIT]           = flag_q;
  end
endmodule

// File: rtl/win_decoder_chk.sv
module win_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int BASE_W = 24,
  parameter int SIZE_W = 5,
  parameter logic [ADDR_W-BASE_W-1:0] TOP_VAL = 'h1F
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              reg_wr,
  input logic              reg_sel,
  input logic [ADDR_W-1:0] reg_wdata,
  input logic              win_hit,
  input logic              addr_err,
  input logic [ADDR_W-1:0] base_rdata,
  input logic [ADDR_W-1:0] ctrl_rdata
);
  import win_pkg::*;

  logic clear_wr;
  logic area_acc;
  assign clear_wr = reg_wr && reg_sel && reg_wdata[CTRL_FLAG_BIT];
  assign area_acc = acc_valid && (acc_addr[ADDR_W-1:BASE_W] == TOP_VAL);

  a_r2_fixed_top: assert property (@(posedge clk) disable iff (rst)
    base_rdata[ADDR_W-1:BASE_W] == TOP_VAL);

  a_r3_zero_gap: assert property (@(posedge clk) disable iff (rst)
    ctrl_rdata[CTRL_SIZE_LSB+SIZE_W +: 3] == 3'b000);

  a_r6_err_from_area: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> $past(area_acc));

  a_r7_hit_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    win_hit |-> $past(acc_valid));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(win_hit && addr_err));

  a_r8_flag_with_err: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> ctrl_rdata[CTRL_FLAG_BIT]);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_rdata[CTRL_FLAG_BIT]) && !$past(clear_wr)) |-> ctrl_rdata[CTRL_FLAG_BIT]);

  a_r9_clear_works: assert property (@(posedge clk) disable iff (rst)
    ($past(clear_wr) && !addr_err) |-> !ctrl_rdata[CTRL_FLAG_BIT]);
endmodule

bind win_decoder win_decoder_chk #(
  .ADDR_W(ADDR_W), .BASE_W(BASE_W), .SIZE_W(SIZE_W), .TOP_VAL(TOP_VAL)
) u_chk (.*);

// File: tb/win_decoder_tb.sv
`timescale 1ns/1ps
module win_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        win_hit, addr_err;
  logic [31:0] base_rdata, ctrl_rdata;

  int checks = 0;
  int fails  = 0;

  // Behavioural reference state
  longint m_base = 0;
  longint m_size = 0;
  bit     m_flag = 1'b0;
  bit     e_hit  = 1'b0;
  bit     e_err  = 1'b0;

  always #4 clk = ~clk;

  win_decoder u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .win_hit(win_hit), .addr_err(addr_err),
    .base_rdata(base_rdata), .ctrl_rdata(ctrl_rdata)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "win_hit",    {31'b0, win_hit},  {31'b0, e_hit});
    chk(tag, "addr_err",   {31'b0, addr_err}, {31'b0, e_err});
    chk(tag, "base_rdata", base_rdata, 32'h1F000000 | 32'(m_base));
    chk(tag, "ctrl_rdata", ctrl_rdata, 32'(m_size << 16) | (32'(m_flag) << 28));
  endtask

  // Drive one cycle (from a negedge), update the model, compare at next negedge
  task automatic step(input logic v, input logic [31:0] a, input logic w,
                      input logic sel, input logic [31:0] d, input string tag);
    longint eff, span, lo, addr_l;
    bit inwin, area;
    acc_valid = v; acc_addr = a; reg_wr = w; reg_sel = sel; reg_wdata = d;
    addr_l = longint'(a);
    eff    = 64'h1F000000 | m_base;
    span   = 64'd1 << m_size;
    lo     = (eff / span) * span;
    inwin  = (addr_l >= lo) && (addr_l < lo + span);
    area   = ((addr_l >> 24) == 64'h1F);
    e_hit  = v && inwin;
    e_err  = v && area && !inwin;
    if (w && !sel) m_base = longint'(d) & 64'hFFFFFF;
    if (w && sel)  m_size = (longint'(d) >> 16) & 64'h1F;
    if (e_err) m_flag = 1'b1;
    else if (w && sel && d[28]) m_flag = 1'b0;
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 32'h0, 1'b0, 1'b0, 32'h0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    compare_all("R1");
    rst = 1'b0;
    idle("R1");

    // Base write: only low 24 bits stick, top byte reads 1Fh
    step(1'b0, 32'h0, 1'b1, 1'b0, 32'hAB123456, "R2");
    // Control write with junk elsewhere: N=4, reserved bits read 0
    step(1'b0, 32'h0, 1'b1, 1'b1, 32'hFFE4FFFF, "R3");

    // 16-byte window at 1F123450h, low base bits 6h ignored
    step(1'b1, 32'h1F123450, 1'b0, 1'b0, 32'h0, "R4");
    step(1'b1, 32'h1F12345F, 1'b0, 1'b0, 32'h0, "R4");
    step(1'b1, 32'h1F123455, 1'b0, 1'b0, 32'h0, "R4");
    // Just past and just below: back-to-back errors
    step(1'b1, 32'h1F123460, 1'b0, 1'b0, 32'h0, "R6");
    step(1'b1, 32'h1F12344F, 1'b0, 1'b0, 32'h0, "R6");
    idle("R8");

    // No strobe, and outside decode area
    step(1'b0, 32'h1F000000, 1'b0, 1'b0, 32'h0, "R7");
    step(1'b1, 32'h20000000, 1'b0, 1'b0, 32'h0, "R7");
    step(1'b1, 32'h1E123450, 1'b0, 1'b0, 32'h0, "R7");

    // Flag write rules
    step(1'b0, 32'h0, 1'b1, 1'b1, 32'h00040000, "R9");
    idle("R9");
    step(1'b0, 32'h0, 1'b1, 1'b1, 32'h10040000, "R9");
    step(1'b1, 32'h1F000000, 1'b1, 1'b1, 32'h10040000, "R9");
    idle("R8");
    step(1'b0, 32'h0, 1'b1, 1'b1, 32'h10040000, "R9");

    // One-byte window
    step(1'b0, 32'h0, 1'b1, 1'b1, 32'h00000000, "R3");
    step(1'b0, 32'h0, 1'b1, 1'b0, 32'h00000010, "R2");
    step(1'b1, 32'h1F000010, 1'b0, 1'b0, 32'h0, "R4");
    step(1'b1, 32'h1F000011, 1'b0, 1'b0, 32'h0, "R6");
    // Access meeting a base write uses the old base
    step(1'b1, 32'h1F000010, 1'b1, 1'b0, 32'h00000020, "R4");
    step(1'b1, 32'h1F000020, 1'b0, 1'b0, 32'h0, "R4");

    // Wide exponents
    step(1'b0, 32'h0, 1'b1, 1'b1, 32'h10180000, "R5");
    step(1'b1, 32'h1FFFFFFF, 1'b0, 1'b0, 32'h0, "R5");
    step(1'b1, 32'h1F000000, 1'b0, 1'b0, 32'h0, "R5");
    step(1'b1, 32'h1E000000, 1'b0, 1'b0, 32'h0, "R5");
    step(1'b0, 32'h0, 1'b1, 1'b1, 32'h001F0000, "R5");
    step(1'b1, 32'h00000000, 1'b0, 1'b0, 32'h0, "R5");
    step(1'b1, 32'h7FFFFFFF, 1'b0, 1'b0, 32'h0, "R5");
    step(1'b1, 32'h80000000, 1'b0, 1'b0, 32'h0, "R5");
    idle("R7");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule